// File: doc/BRIEF.md
# Display Character Output Port

This block sits on a simple processor bus and passes characters to a character output device. Software stores a byte into the data register. The block then offers that byte to the device through a valid/ready handshake. It holds the byte steady until the device accepts it, which may take many cycles.

A status register carries an output-ready flag. The block sets this flag when the device takes the pending character. A read of the status register clears it, so a polling loop sees each completion exactly once. A second status bit records a store that was dropped because the device was still busy. A control register holds a per-device interrupt enable, and the interrupt request is the ready flag gated by that enable.

The bus has a single-cycle interface. Each cycle carries an address, a read strobe, a write strobe and write data. Read data is combinational, and the side effects of a read take place at the clock edge that ends the cycle.

Top module: `disp_out`

## Requirements
- R1: After reset the status register reads 0x04 (ready flag set, error clear), the control register reads 0x00, `dev_valid` is 0 and `irq` is 0.
- R2: Registers are decoded at byte offsets 0x0 (data, write-only), 0x4 (status) and 0x8 (control). A read of the data offset returns 0.
- R3: A store to offset 0x0 while no character is pending raises `dev_valid` in the next cycle, with the stored byte on `dev_char`. Both stay unchanged until the cycle in which `dev_ready` is 1.
- R4: The ready flag is status bit 2. A status read clears it from the following cycle on, unless R6 applies.
- R5: In the cycle after a handshake (`dev_valid` and `dev_ready` both 1), `dev_valid` is 0 and the ready flag is 1.
- R6: When a status read and a handshake fall in the same cycle, the read returns the old flag value and the flag is 1 afterwards.
- R7: A store to offset 0x0 while `dev_valid` is 1 is dropped, leaving `dev_char` unchanged, and sets the sticky error bit (status bit 0). That bit stays set until a status read clears it.
- R8: Control bit 1 is the interrupt enable and reads back as written. `irq` is 1 exactly when both the enable and the ready flag are 1.
- R9: An accepted store to offset 0x0 clears the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read |
| dev_valid | output | 1 | A character is offered to the device |
| dev_char | output | DATA_W | Character offered to the device |
| dev_ready | input | 1 | Device accepts the offered character |
| irq | output | 1 | Interrupt request |

## Verification
The internal state is small: a busy bit, a ready flag, an error bit and an enable bit. Each of them shows at the ports within one cycle. A busy bit stuck wrong appears on `dev_valid` at once, and it also turns up as a wrongly dropped or wrongly accepted store on the next status read. A ready flag that is wrong in either direction appears on `irq` in the same cycle once the interrupt is enabled. It also appears in bit 2 of the first status read, and the read-versus-completion race is exercised on purpose so that a reversed priority shows on the next read.

// File: rtl/disp_out.sv
module disp_out #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int DATA_OFS = 0,
  parameter int STAT_OFS = 4,
  parameter int CTRL_OFS = 8,
  parameter int ERR_BIT  = 0,
  parameter int IE_BIT   = 1,
  parameter int RDY_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              dev_valid,
  output logic [DATA_W-1:0] dev_char,
  input  logic              dev_ready,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic busy_q, rdy_q, err_q, ie_q;
  logic [DATA_W-1:0] char_q;

  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire rd_stat = bus_rd && bus_addr == A_STAT;
  wire accept  = wr_data && !busy_q;
  wire drop    = wr_data && busy_q;
  wire done    = busy_q && dev_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b1;
      err_q  <= 1'b0;
      ie_q   <= 1'b0;
      char_q <= '0;
    end else begin
      if (accept) begin
        busy_q <= 1'b1;
        char_q <= bus_wdata;
      end else if (done) begin
        busy_q <= 1'b0;
      end

      if (done)                    rdy_q <= 1'b1;
      else if (accept || rd_stat)  rdy_q <= 1'b0;

      if (drop)         err_q <= 1'b1;
      else if (rd_stat) err_q <= 1'b0;

      if (wr_ctrl) ie_q <= bus_wdata[IE_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == A_STAT) begin
        bus_rdata[RDY_BIT] = rdy_q;
        bus_rdata[ERR_BIT] = err_q;
      end else if (bus_addr == A_CTRL) begin
        bus_rdata[IE_BIT] = ie_q;
      end
    end
  end

  assign dev_valid = busy_q;
  assign dev_char  = char_q;
  assign irq       = rdy_q & ie_q;
endmodule

// File: rtl/disp_out_chk.sv
module disp_out_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int DATA_OFS = 0,
  parameter int STAT_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              dev_valid,
  input logic [DATA_W-1:0] dev_char,
  input logic              dev_ready,
  input logic              irq,
  input logic              rdy,
  input logic              err,
  input logic              ie
);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_char));

  a_r5_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && dev_ready |=> !dev_valid && rdy);

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == ADDR_W'(STAT_OFS) && !(dev_valid && dev_ready) |=> !rdy);

  a_r7_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(DATA_OFS) && dev_valid && !dev_ready
      |=> err && $stable(dev_char));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);

  a_r9_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(DATA_OFS) && !dev_valid |=> dev_valid && !rdy);
endmodule

bind disp_out disp_out_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .dev_valid(dev_valid), .dev_char(dev_char), .dev_ready(dev_ready), .irq(irq),
  .rdy(rdy_q), .err(err_q), .ie(ie_q)
);

// File: tb/sim_disp_out.sv
module sim_disp_out;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = '0;
  logic bus_rd = 0, bus_wr = 0, dev_ready = 0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, dev_char;
  logic dev_valid, irq;
  int checks = 0, errors = 0;
  bit wd_fired = 0;

  always #2 clk = ~clk;

  disp_out u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_valid(dev_valid), .dev_char(dev_char), .dev_ready(dev_ready), .irq(irq));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic complete();
    @(negedge clk); dev_ready = 1;
    @(negedge clk); dev_ready = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 dev_valid", 8'(dev_valid), 8'h0);
    chk("R1 irq", 8'(irq), 8'h0);
    rd(4'h8, v); chk("R1 ctrl", v, 8'h00);
    rd(4'h0, v); chk("R2 data read", v, 8'h00);
    rd(4'h4, v); chk("R1 status", v, 8'h04);
    rd(4'h4, v); chk("R4 cleared by read", v, 8'h00);
  endtask

  task automatic t_send();
    logic [7:0] v;
    wr(4'h0, 8'h41);
    chk("R3 valid", 8'(dev_valid), 8'h1);
    chk("R3 char", dev_char, 8'h41);
    repeat (5) @(negedge clk);
    chk("R3 held valid", 8'(dev_valid), 8'h1);
    chk("R3 held char", dev_char, 8'h41);
    wr(4'h0, 8'h42);
    chk("R7 char kept", dev_char, 8'h41);
    rd(4'h4, v); chk("R7 error set", v, 8'h01);
    rd(4'h4, v); chk("R7 error cleared", v, 8'h00);
    complete();
    chk("R5 valid drop", 8'(dev_valid), 8'h0);
    rd(4'h4, v); chk("R5 ready set", v, 8'h04);
  endtask

  task automatic t_accept_clears();
    logic [7:0] v;
    rd(4'h4, v); chk("R4 flag currently clear", v, 8'h00);
    complete();
    wr(4'h0, 8'h10);
    chk("R3 new char", dev_char, 8'h10);
    complete();
    wr(4'h0, 8'h11);
    rd(4'h4, v); chk("R9 store clears ready", v, 8'h00);
    complete();
  endtask

  task automatic t_race();
    logic [7:0] v;
    rd(4'h4, v);
    wr(4'h0, 8'h55);
    @(negedge clk); bus_addr = 4'h4; bus_rd = 1; dev_ready = 1;
    #1 v = bus_rdata;
    chk("R6 old value returned", v, 8'h00);
    @(negedge clk); bus_rd = 0; dev_ready = 0;
    rd(4'h4, v); chk("R6 completion wins", v, 8'h04);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    wr(4'h8, 8'h02);
    rd(4'h8, v); chk("R8 ctrl readback", v, 8'h02);
    chk("R8 irq low flag clear", 8'(irq), 8'h0);
    wr(4'h0, 8'h61);
    complete();
    chk("R8 irq high", 8'(irq), 8'h1);
    rd(4'h4, v);
    chk("R8 irq cleared by read", 8'(irq), 8'h0);
    wr(4'h8, 8'h00);
    wr(4'h0, 8'h62);
    complete();
    chk("R8 irq masked", 8'(irq), 8'h0);
    rd(4'h4, v); chk("R8 flag still set", v, 8'h04);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_send();
        t_accept_clears();
        t_race();
        t_irq();
      end
      begin
        repeat (20000) @(posedge clk);
        wd_fired = 1;
      end
    join_any
    disable fork;
    if (wd_fired) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule